// File: doc/BRIEF.md
# Triggered Channel Timing Sequencer

This block is the timing controller for a single detector channel. It replaces an analogue ramp and its comparators with a counter. A pulse from the channel's constant-fraction discriminator starts a count with a 10 ns tick. Every action the channel takes during an event is placed by comparing that count with a programmable set point. With the default 10-bit width the timebase spans 1024 ticks, about 10 µs.

Five set points place the events in time:
- the close of the fast-trigger window;
- the deadline for validation from the central trigger;
- the moment the peak-hold gate closes and ADC conversion is commanded;
- the length of the busy (dead-time) signal;
- the readout strobe.

The sequence ends in one of four ways: it completes at the readout point, it aborts for lack of validation, it is rejected from outside, or it reaches the last count. In every case the channel goes back to idle. Discriminator pulses that arrive while a sequence is running are reported as pileup and do not restart the count.

Top module: `chan_timing_seq`

## Requirements
- R1: After reset, `active_o`, `ftrig_win_o`, `pk_gate_o`, `conv_start_o`, `busy_o`, `readout_o` and `pileup_o` are low, and every set point reads back 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` in the set point chosen by `cfg_sel`. The codes are 0 fast-trigger end, 1 validation end, 2 hold/convert, 3 busy width and 4 readout. `cfg_rdata` returns the selected set point unchanged. Codes 5 to 7 read 0, and writes to them are ignored.
- R3: In idle, a `cfd_i` pulse without `reject_i` makes `active_o` high from the next cycle. The count is 0 in that first active cycle and rises by 1 each cycle after.
- R4: `ftrig_win_o` is high while active and the count is below the fast-trigger set point.
- R5: `pk_gate_o` is high from the start of the sequence while the count is below the hold/convert set point. It is therefore low in the cycle of the conversion command.
- R6: `conv_start_o` is a one-cycle strobe. It fires when the count equals the hold/convert set point, but only if validation has already been accepted.
- R7: `busy_o` is high while active and the count is below the busy-width set point.
- R8: If validation has been accepted, `readout_o` pulses when the count equals the readout set point, and the channel is idle in the next cycle.
- R9: `validate_i` is accepted only while the count is below the validation set point. If the count reaches that set point with no validation accepted, the channel is idle in the next cycle.
- R10: `reject_i` makes the channel idle in the next cycle. It takes priority over every other input, including a `cfd_i` pulse in the same cycle while idle.
- R11: A `cfd_i` pulse while active raises `pileup_o` in that cycle and leaves the count running undisturbed. `pileup_o` is never high while idle.
- R12: A sequence whose count reaches 2^CW-1 is forced idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timebase tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfd_i | input | 1 | Discriminator pulse, one cycle |
| validate_i | input | 1 | Validation from the central trigger |
| reject_i | input | 1 | Event reject from the central trigger |
| cfg_we | input | 1 | Set-point write enable |
| cfg_sel | input | 3 | Set-point select |
| cfg_wdata | input | CW | Set-point write data |
| cfg_rdata | output | CW | Selected set point |
| active_o | output | 1 | Sequence running |
| ftrig_win_o | output | 1 | Fast-trigger window open |
| pk_gate_o | output | 1 | Peak-detect gate |
| conv_start_o | output | 1 | ADC conversion command |
| busy_o | output | 1 | Busy / dead time |
| readout_o | output | 1 | Readout strobe |
| pileup_o | output | 1 | Discriminator pulse during a sequence |

## Verification
The bench builds the block with CW at its default of 10, so the full timebase is used. That width keeps a sequence that runs out to count 1023 within about a thousand cycles, so the terminal-count path (R12) can be exercised directly. One scenario places the readout point before a late validation, so that path is reached on its own and not through a normal completion. Other scenarios cover:
- validation arriving exactly at its deadline;
- a conversion point that falls before validation;
- a reject that coincides with a discriminator pulse in idle.

// File: rtl/chan_timing_seq.sv
module chan_timing_seq #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfd_i,
  input  logic          validate_i,
  input  logic          reject_i,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [CW-1:0] cfg_wdata,
  output logic [CW-1:0] cfg_rdata,
  output logic          active_o,
  output logic          ftrig_win_o,
  output logic          pk_gate_o,
  output logic          conv_start_o,
  output logic          busy_o,
  output logic          readout_o,
  output logic          pileup_o
);
  localparam int NSP = 5;
  localparam logic [2:0] NSP_C = 3'(NSP);
  localparam logic [CW-1:0] LAST = '1;

  logic [CW-1:0] sp [NSP];
  logic          run, vld;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSP; i++) sp[i] <= '0;
    end else if (cfg_we && cfg_sel < NSP_C) begin
      sp[cfg_sel] <= cfg_wdata;
    end
  end

  assign cfg_rdata = (cfg_sel < NSP_C) ? sp[cfg_sel] : '0;

  wire [CW-1:0] t_ftw  = sp[0];
  wire [CW-1:0] t_val  = sp[1];
  wire [CW-1:0] t_hold = sp[2];
  wire [CW-1:0] t_busy = sp[3];
  wire [CW-1:0] t_ro   = sp[4];

  wire fin = (cnt == LAST) || (vld ? (cnt == t_ro) : (cnt == t_val));

  always_ff @(posedge clk) begin
    if (!rst_n || reject_i) begin
      run <= 1'b0;
      vld <= 1'b0;
      cnt <= '0;
    end else if (!run) begin
      if (cfd_i) begin
        run <= 1'b1;
        vld <= 1'b0;
        cnt <= '0;
      end
    end else if (fin) begin
      run <= 1'b0;
      vld <= 1'b0;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (validate_i && cnt < t_val) vld <= 1'b1;
    end
  end

  assign active_o     = run;
  assign ftrig_win_o  = run && (cnt < t_ftw);
  assign pk_gate_o    = run && (cnt < t_hold);
  assign conv_start_o = run && vld && (cnt == t_hold);
  assign busy_o       = run && (cnt < t_busy);
  assign readout_o    = run && vld && (cnt == t_ro);
  assign pileup_o     = run && cfd_i;
endmodule

// File: rtl/chan_timing_seq_chk.sv
module chan_timing_seq_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfd_i,
  input logic          reject_i,
  input logic          active_o,
  input logic          pk_gate_o,
  input logic          conv_start_o,
  input logic          readout_o,
  input logic          pileup_o,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = '1;

  a_r3_cfd_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && cfd_i && !reject_i) |=> active_o);

  a_r5_gate_closed_at_conv: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> !pk_gate_o);

  a_r6_conv_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

  a_r8_ro_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    readout_o |=> !active_o);

  a_r10_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reject_i |=> !active_o);

  a_r11_pileup_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    pileup_o |-> active_o);

  a_r12_terminal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && cnt == LAST) |=> !active_o);
endmodule

bind chan_timing_seq chan_timing_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfd_i(cfd_i), .reject_i(reject_i),
  .active_o(active_o), .pk_gate_o(pk_gate_o), .conv_start_o(conv_start_o),
  .readout_o(readout_o), .pileup_o(pileup_o), .cnt(cnt)
);

// File: tb/test_chan_timing_seq.sv
module test_chan_timing_seq;
  localparam int CLK_NS = 10;
  localparam int CW = 10;
  localparam int LAST = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfd_i = 1'b0, validate_i = 1'b0, reject_i = 1'b0, cfg_we = 1'b0;
  logic [2:0] cfg_sel = 3'd0;
  logic [CW-1:0] cfg_wdata = '0, cfg_rdata;
  logic active_o, ftrig_win_o, pk_gate_o, conv_start_o, busy_o, readout_o, pileup_o;

  chan_timing_seq #(.CW(CW)) i_chan_timing_seq (
    .clk(clk), .rst_n(rst_n), .cfd_i(cfd_i), .validate_i(validate_i),
    .reject_i(reject_i), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .active_o(active_o), .ftrig_win_o(ftrig_win_o),
    .pk_gate_o(pk_gate_o), .conv_start_o(conv_start_o), .busy_o(busy_o),
    .readout_o(readout_o), .pileup_o(pileup_o)
  );

  initial forever #(CLK_NS/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int m_sp[5];
  bit m_run = 0, m_vld = 0;
  int m_cnt = 0;
  bit cap_act, cap_pile;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    int e_rd;
    bit e_ftw, e_pk, e_cs, e_busy, e_ro, e_pile;
    e_rd   = (cfg_sel < 5) ? m_sp[cfg_sel] : 0;
    e_ftw  = m_run && m_cnt < m_sp[0];
    e_pk   = m_run && m_cnt < m_sp[2];
    e_cs   = m_run && m_vld && m_cnt == m_sp[2];
    e_busy = m_run && m_cnt < m_sp[3];
    e_ro   = m_run && m_vld && m_cnt == m_sp[4];
    e_pile = m_run && cfd_i;
    chk(int'(cfg_rdata) == e_rd, "R2 cfg_rdata", int'(cfg_rdata), e_rd);
    chk(active_o == m_run, "R3 active_o", active_o, m_run);
    chk(ftrig_win_o == e_ftw, "R4 ftrig_win_o", ftrig_win_o, e_ftw);
    chk(pk_gate_o == e_pk, "R5 pk_gate_o", pk_gate_o, e_pk);
    chk(conv_start_o == e_cs, "R6 conv_start_o", conv_start_o, e_cs);
    chk(busy_o == e_busy, "R7 busy_o", busy_o, e_busy);
    chk(readout_o == e_ro, "R8 readout_o", readout_o, e_ro);
    chk(pileup_o == e_pile, "R11 pileup_o", pileup_o, e_pile);
  endtask

  task automatic step(input bit c, input bit v, input bit r,
                      input bit we, input int sel, input int wd);
    bit fin;
    @(negedge clk);
    cfd_i = c; validate_i = v; reject_i = r;
    cfg_we = we; cfg_sel = 3'(sel); cfg_wdata = CW'(wd);
    #1;
    compare();
    cap_act = active_o;
    cap_pile = pileup_o;
    @(posedge clk);
    if (r) begin
      m_run = 0; m_vld = 0; m_cnt = 0;
    end else if (!m_run) begin
      if (c) begin m_run = 1; m_vld = 0; m_cnt = 0; end
    end else begin
      fin = (m_cnt == LAST) || (m_vld ? m_cnt == m_sp[4] : m_cnt == m_sp[1]);
      if (fin) begin
        m_run = 0; m_vld = 0; m_cnt = 0;
      end else begin
        if (v && m_cnt < m_sp[1]) m_vld = 1;
        m_cnt++;
      end
    end
    if (we && sel < 5) m_sp[sel] = wd;
  endtask

  task automatic wr(input int sel, input int wd);
    step(0, 0, 0, 1, sel, wd);
  endtask

  task automatic rd(input int sel);
    step(0, 0, 0, 0, sel, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    foreach (m_sp[i]) m_sp[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R1 reset state
    chk({active_o, ftrig_win_o, pk_gate_o, conv_start_o, busy_o, readout_o, pileup_o} == 7'b0,
        "R1 outputs in reset", int'(active_o), 0);
    chk(cfg_rdata == '0, "R1 set point after reset", int'(cfg_rdata), 0);
    rst_n = 1'b1;
    for (int s = 0; s < 8; s++) rd(s);

    // R2 program and read back; unused code ignored
    wr(0, 5); wr(1, 20); wr(2, 30); wr(3, 40); wr(4, 45);
    wr(6, 'h2AA);
    for (int s = 0; s < 8; s++) rd(s);

    // Full sequence with pileup pulse; R8 completion
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 50; i++) begin
      step(i == 15, i == 10, 0, 0, i % 5, 0);
      if (i == 15) chk(cap_pile == 1, "R11 pileup during run", cap_pile, 1);
      if (i == 45) chk(cap_act == 1, "R8 active at readout", cap_act, 1);
      if (i == 46) chk(cap_act == 0, "R8 idle after readout", cap_act, 0);
    end

    // R9 no validation
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 25; i++) begin
      step(0, 0, 0, 0, 0, 0);
      if (i == 20) chk(cap_act == 1, "R9 active at deadline", cap_act, 1);
      if (i == 21) chk(cap_act == 0, "R9 idle after deadline", cap_act, 0);
    end

    // R9 validation exactly at deadline is refused
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 25; i++) begin
      step(0, i == 20, 0, 0, 0, 0);
      if (i == 21) chk(cap_act == 0, "R9 late validation", cap_act, 0);
    end

    // R6 conversion point before validation: no strobe
    wr(1, 35);
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 50; i++) step(0, i == 32, 0, 0, 0, 0);
    wr(1, 20);

    // R10 reject mid-run, then reject with cfd in idle
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) begin
      step(0, i == 2, i == 5, 0, 0, 0);
      if (i == 6) chk(cap_act == 0, "R10 reject mid-run", cap_act, 0);
    end
    step(1, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    chk(cap_act == 0, "R10 reject beats cfd", cap_act, 0);

    // R12 terminal count: readout passed before late validation
    wr(1, LAST); wr(4, 3);
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i <= LAST; i++) step(0, i == 10, 0, 0, 0, 0);
    chk(cap_act == 1, "R12 active at last count", cap_act, 1);
    step(0, 0, 0, 0, 0, 0);
    chk(cap_act == 0, "R12 idle after last count", cap_act, 0);

    repeat (3) step(0, 0, 0, 0, 0, 0);
    summary();
    $finish;
  end
endmodule